// File: doc/BRIEF.md
# Single-Clock FIFO with Run-Time Level Thresholds

This block is a first-in first-out buffer running on one clock. It holds its own storage array and two address counters, one for the write side and one for the read side. It keeps an occupancy count and reports four status flags. Two of these flags, empty and full, have fixed meanings. The other two give early warning. Each of them compares the occupancy against a threshold that logic outside the block can change on any cycle.

A producer asserts the push strobe together with a data word. A consumer asserts the pop strobe and takes the word one clock later. The block ignores a push while it is full and a pop while it is empty, so neither side has to gate its strobe against the flags. Data width and depth are elaboration parameters. The depth does not have to be a power of two.

Top module: `sync_fifo_thresh`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `empty`=1, `almost_empty`=1, `full`=0, `rd_data`=0 and the occupancy is zero. With `af_level`≥1 this gives `almost_full`=0.
- R2: Words leave in the order they were accepted. A pop accepted at clock edge N shows its word on `rd_data` after edge N, and `rd_data` holds its value at every edge that accepts no pop.
- R3: `empty` is 1 exactly when the occupancy is 0, and `full` is 1 exactly when the occupancy equals DEPTH.
- R4: A push while `full`=1 is dropped. The stored words and the occupancy are unchanged, and no dropped word is ever read out.
- R5: A pop while `empty`=1 is dropped. `rd_data` holds, the flags are unchanged, and the words written later read back correctly.
- R6: A push and a pop on the same edge, with the FIFO neither empty nor full, leave the occupancy unchanged and keep the order of the words.
- R7: `almost_empty` is 1 exactly when occupancy ≤ `ae_level`. Both are unsigned values of width ceil(log2(DEPTH+1)).
- R8: `almost_full` is 1 exactly when occupancy ≥ `af_level`, compared as unsigned values of the same width.
- R9: A change on `ae_level` or `af_level` reaches the almost flags in the same cycle, with no clock edge needed.
- R10: Both address counters advance by one for each accepted operation, wrap from DEPTH-1 to 0, and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push strobe |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | DATA_W | Registered word from the last accepted pop |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| almost_empty | output | 1 | Occupancy ≤ ae_level |
| almost_full | output | 1 | Occupancy ≥ af_level |
| ae_level | input | ceil(log2(DEPTH+1)) | Low-water threshold |
| af_level | input | ceil(log2(DEPTH+1)) | High-water threshold |

## Verification
The bench pushes past full, pops past empty, and strobes both sides at once while the FIFO sits at full, at empty and at every level in between. A design that let an overflow write through would later return a dropped marker word. One that moved the read counter on a blocked pop would return data out of order or change `rd_data`. Long runs of simultaneous push and pop carry both counters around the wrap point many times, which exposes an off-by-one in the wrap or a count that drifts. At each occupancy from 0 to DEPTH, every pair of thresholds is applied and checked without a clock edge. This catches comparisons that use the wrong inequality at the boundary and flags that were registered by mistake.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef struct packed {
        logic empty;
        logic full;
        logic almost_empty;
        logic almost_full;
    } fifo_status_t;

    // Accepted operation on one edge: bit0 = push taken, bit1 = pop taken
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int unsigned level_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam bit            POW2 = ((1 << AW) == DEPTH);

    logic [AW-1:0] ptr_nx;

    generate
        if (POW2) begin : g_natural_wrap
            always_comb ptr_nx = ptr + AW'(1);
        end else begin : g_compare_wrap
            always_comb ptr_nx = (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr_nx;
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr)) else $error("counter moved without an accepted operation");

    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr == LAST) |=> (ptr == '0)) else $error("counter failed to wrap");

    a_r10_range: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST) else $error("counter out of range");

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= cells[raddr];
    end

    a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata)) else $error("read port changed without a pop");

endmodule

// File: rtl/sfifo_level.sv
module sfifo_level
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_op_e      op,
    input  logic [CW-1:0] ae_level,
    input  logic [CW-1:0] af_level,
    output fifo_status_t  status
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [CW-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            unique case (op)
                OP_PUSH: occ <= occ + CW'(1);
                OP_POP:  occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
        end
    end

    always_comb begin
        status.empty        = (occ == '0);
        status.full         = (occ == CAP);
        status.almost_empty = (occ <= ae_level);
        status.almost_full  = (occ >= af_level);
    end

    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= CAP) else $error("occupancy exceeds depth");

    a_r6_both_stable: assert property (@(posedge clk) disable iff (rst)
        op == OP_BOTH |=> $stable(occ)) else $error("simultaneous push/pop changed occupancy");

    a_r3_push_grows: assert property (@(posedge clk) disable iff (rst)
        op == OP_PUSH |=> !status.empty) else $error("empty after accepted push");

endmodule

// File: rtl/sync_fifo_thresh.sv
module sync_fifo_thresh
    import sfifo_pkg::*;
#(
    parameter  int unsigned DATA_W = 8,
    parameter  int unsigned DEPTH  = 16,
    localparam int unsigned CW     = level_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full,
    input  logic [CW-1:0]     ae_level,
    input  logic [CW-1:0]     af_level
);
    localparam int unsigned AW = addr_bits(DEPTH);

    fifo_status_t  st;
    fifo_op_e      op;
    logic          push_ok, pop_ok;
    logic [AW-1:0] wptr, rptr;

    always_comb begin
        push_ok = wr_en && !st.full;
        pop_ok  = rd_en && !st.empty;
        op      = fifo_op_e'({pop_ok, push_ok});
    end

    sfifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk(clk), .rst(rst), .adv(push_ok), .ptr(wptr)
    );

    sfifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk(clk), .rst(rst), .adv(pop_ok), .ptr(rptr)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst(rst),
        .we(push_ok), .waddr(wptr), .wdata(wr_data),
        .re(pop_ok),  .raddr(rptr), .rdata(rd_data)
    );

    sfifo_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
        .clk(clk), .rst(rst), .op(op),
        .ae_level(ae_level), .af_level(af_level), .status(st)
    );

    assign empty        = st.empty;
    assign full         = st.full;
    assign almost_empty = st.almost_empty;
    assign almost_full  = st.almost_full;

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && $stable(wptr)))
        else $error("push while full was taken");

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rptr) && $stable(rd_data)))
        else $error("pop while empty was taken");

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(empty && full)) else $error("empty and full together");

endmodule

// File: tb/tb_sync_fifo_thresh.sv
`timescale 1ns/1ps
module tb_sync_fifo_thresh;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          empty, full, almost_empty, almost_full;
    logic [CW-1:0] ae_level = CW'(2), af_level = CW'(6);

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] model[$];
    logic [DW-1:0] last_rd = '0;
    logic [DW-1:0] seq = 8'h10;

    always #4 clk = ~clk;

    sync_fifo_thresh #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full),
        .ae_level(ae_level), .af_level(af_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_flags(input string tag);
        int n = model.size();
        logic [3:0] exp, act;
        exp = {n == 0, n == DEPTH, n <= int'(ae_level), n >= int'(af_level)};
        act = {empty, full, almost_empty, almost_full};
        chk(act == exp, tag, act, exp);
    endtask

    task automatic step(input bit we, input logic [DW-1:0] wd, input bit re, input string tag);
        bit pop_exp, push_exp;
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re;
        pop_exp  = re && model.size() > 0;
        push_exp = we && model.size() < DEPTH;
        @(posedge clk); #1;
        if (pop_exp) last_rd = model.pop_front();
        chk(rd_data == last_rd, {tag, " R2 data"}, rd_data, last_rd);
        if (push_exp) model.push_back(wd);
        chk_flags({tag, " R3 flags"});
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic push(input string tag);
        seq = seq + 8'd1;
        step(1'b1, seq, 1'b0, tag);
    endtask

    initial begin
        #(LIMIT * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: flags and read port during reset
        chk({empty, full, almost_empty, almost_full} == 4'b1010, "R1 flags in reset",
            {empty, full, almost_empty, almost_full}, 4'b1010);
        chk(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk({empty, full, almost_empty, almost_full} == 4'b1010, "R1 flags after reset",
            {empty, full, almost_empty, almost_full}, 4'b1010);

        // R5: pops on an empty FIFO are dropped
        step(1'b0, '0, 1'b1, "R5 pop empty");
        step(1'b1, 8'hEE, 1'b1, "R5 pop empty with push");
        step(1'b0, '0, 1'b1, "R5 read back");

        // Fill past full; R4 overflow words use marker EE
        for (int i = 0; i < DEPTH; i++) push("R8 fill");
        for (int i = 0; i < 3; i++) step(1'b1, 8'hEE, 1'b0, "R4 push full");
        step(1'b1, 8'hEE, 1'b1, "R4 push+pop at full");
        push("R4 refill");

        // Drain past empty
        for (int i = 0; i < DEPTH + 3; i++) step(1'b0, '0, 1'b1, "R5 drain");

        // R6 and R10: steady simultaneous traffic wraps both counters
        for (int i = 0; i < 3; i++) push("R6 prime");
        for (int i = 0; i < 5 * DEPTH; i++) begin
            seq = seq + 8'd1;
            step(1'b1, seq, 1'b1, "R6 R10 both");
        end
        for (int lvl = 1; lvl < DEPTH; lvl++) begin
            while (model.size() < lvl) push("R6 level");
            for (int i = 0; i < 3; i++) begin
                seq = seq + 8'd1;
                step(1'b1, seq, 1'b1, "R6 both at level");
            end
        end
        while (model.size() > 0) step(1'b0, '0, 1'b1, "R10 drain");

        // R7 R8 R9: every threshold pair at every occupancy, no clock edge
        for (int n = 0; n <= DEPTH; n++) begin
            while (model.size() < n) push("R7 build");
            for (int a = 0; a <= DEPTH; a++) begin
                for (int f = 0; f <= DEPTH; f++) begin
                    @(negedge clk);
                    ae_level = CW'(a); af_level = CW'(f);
                    #1;
                    chk_flags("R7 R8 R9 threshold sweep");
                end
            end
        end
        ae_level = CW'(2); af_level = CW'(6);
        while (model.size() > 0) step(1'b0, '0, 1'b1, "R4 final drain");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule